// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block owns the command pins of one DDR SDRAM channel from reset until the channel can carry normal traffic. Out of reset the memory clock is gated, CKE is low and the command bus idles, so every device on the channel keeps its outputs in high impedance. Software starts the clock with a level request. The block then counts a programmable stabilization time in memory clock cycles. After that time, a one-cycle power-down-clear strobe raises CKE and starts a fixed command script: precharge all, extended mode set, mode set with DLL reset, precharge all, two auto-refreshes, and a final mode set for normal operation.

Each command is followed by a programmable number of NOP cycles, and tMRD applies after every mode set. A second counter starts at the DLL-reset command. The ready flag rises only after the script is complete and that counter has expired. No command leaves the block once ready is high.

A power-down request drops CKE and ready. This covers a power-down exit with the DLL disabled, where the full script must run again. The next clear strobe then reruns the whole script without a fresh stabilization wait.

Top module: `ddr_init_seq`

## Requirements
- R1: During and after reset, with the clock request low: mem_clk_en_o=0, cke_o=0, ready_o=0, and the command pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1).
- R2: mem_clk_en_o rises the cycle after clk_en_i is sampled high. Whenever clk_en_i is sampled low, the next cycle shows the clock gated, cke_o=0, ready_o=0 and NOP.
- R3: A clear strobe sampled at clock edge g, counted from the edge e that started the clock, is ignored while g < e+STAB_CYC+1 (cke_o stays 0). An accepted strobe raises cke_o in the cycle after the edge.
- R4: After CKE rises there are T_XP NOP cycles. Then come three commands in this order. Precharge all: ras_n=0, cas_n=1, we_n=0, A10=1. Extended mode set: ras_n=cas_n=we_n=0, BA=01, A0=0 (DLL on), A1=drv_weak_i, all other address bits 0. Mode set with DLL reset: BA=00, A8=1.
- R5: After every mode or extended mode set, at least T_MRD NOP cycles pass before the next command.
- R6: After tMRD come, in order: precharge all, T_RP NOPs, auto-refresh (ras_n=cas_n=0, we_n=1, BA=00, A=0), T_RFC NOPs, a second auto-refresh, T_RFC NOPs, and the final mode set. There are T_RP NOPs after the first precharge as well.
- R7: Both mode sets carry A[2:0]=010 (burst length 4), A3=0 (sequential) and A[6:4]=cas_lat_i, with every other bit 0 except A8, which is 1 in the DLL-reset set. The final set has A8=0 and BA=00.
- R8: ready_o rises at the later of two points: T_MRD+1 edges after the final mode set, or DLL_CYC+1 edges after the DLL-reset command. It stays low before that. While ready_o is high, no command other than NOP is driven and CKE stays high.
- R9: A power-down request taken during the script or while ready drops cke_o and ready_o in the next cycle, and no further command is issued. A later clear strobe is accepted at once and reruns the whole script from the first precharge. During stabilization the request has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock, same rate as the memory clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Software clock-run request (level) |
| pdn_clr_i | input | 1 | Power-down clear strobe, starts the script |
| pdn_req_i | input | 1 | Power-down request strobe |
| cas_lat_i | input | 3 | CAS latency field for the mode set |
| drv_weak_i | input | 1 | Reduced output drive select for the extended mode set |
| mem_clk_en_o | output | 1 | Memory clock gate enable |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address bus |
| ready_o | output | 1 | Channel initialized |

## Verification
The checker watches several properties on every cycle. It confirms that a gated clock implies CKE low and ready low, that CKE low implies NOP, and that CKE never rises before the stabilization count. It also confirms tMRD after each mode set, that ready never rises before DLL_CYC cycles have passed since the DLL-reset command, and that the bus stays silent while ready.

Other behaviour can only be shown by the bench scenarios:
- the exact cycle of each command;
- the command order and the address and bank fields;
- the exact ready cycle when the DLL wait dominates;
- reruns after a power-down taken while ready or partway through the script.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;
  typedef enum logic [1:0] {S_OFF, S_STAB, S_SEQ, S_RDY} st_e;
  typedef enum logic [2:0] {C_NOP, C_PRE, C_EMRS, C_MRS_DLL, C_AR, C_MRS_RUN} cmd_e;
  localparam logic [2:0] LAST_STEP = 3'd7;
  localparam logic [2:0] BL4_CODE  = 3'b010;
endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_init_step.sv
// Script table: step 0 is the CKE-raise slot, steps 1..7 are commands.
module ddr_init_step
  import ddr_init_pkg::*;
#(
  parameter int TW    = 8,
  parameter int T_XP  = 1,
  parameter int T_RP  = 3,
  parameter int T_MRD = 2,
  parameter int T_RFC = 18
) (
  input  logic [2:0]    idx_i,
  output cmd_e          cmd_o,
  output logic [TW-1:0] gap_o
);
  always_comb begin
    cmd_o = C_NOP;
    gap_o = TW'(T_MRD);
    unique case (idx_i)
      3'd0: begin cmd_o = C_NOP;     gap_o = TW'(T_XP);  end
      3'd1: begin cmd_o = C_PRE;     gap_o = TW'(T_RP);  end
      3'd2: begin cmd_o = C_EMRS;    gap_o = TW'(T_MRD); end
      3'd3: begin cmd_o = C_MRS_DLL; gap_o = TW'(T_MRD); end
      3'd4: begin cmd_o = C_PRE;     gap_o = TW'(T_RP);  end
      3'd5: begin cmd_o = C_AR;      gap_o = TW'(T_RFC); end
      3'd6: begin cmd_o = C_AR;      gap_o = TW'(T_RFC); end
      3'd7: begin cmd_o = C_MRS_RUN; gap_o = TW'(T_MRD); end
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  cmd_e              cmd_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              drv_weak_i,
  output logic [3:0]        ctl_o,   // {cs_n, ras_n, cas_n, we_n}
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_comb begin
    ctl_o  = 4'b0111;
    ba_o   = 2'b00;
    addr_o = '0;
    unique case (cmd_i)
      C_PRE: begin
        ctl_o      = 4'b0010;
        addr_o[10] = 1'b1;
      end
      C_EMRS: begin
        ctl_o     = 4'b0000;
        ba_o      = 2'b01;
        addr_o[1] = drv_weak_i;
      end
      C_MRS_DLL, C_MRS_RUN: begin
        ctl_o       = 4'b0000;
        addr_o[2:0] = BL4_CODE;
        addr_o[6:4] = cas_lat_i;
        addr_o[8]   = (cmd_i == C_MRS_DLL);
      end
      C_AR: ctl_o = 4'b0001;
      default: ;
    endcase
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int STAB_CYC = 50000,
  parameter int DLL_CYC  = 200,
  parameter int T_XP     = 1,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic              pdn_clr_i,
  input  logic              pdn_req_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              drv_weak_i,
  output logic              mem_clk_en_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o
);
  localparam int GAP_A    = (T_XP > T_RP) ? T_XP : T_RP;
  localparam int GAP_B    = (T_MRD > T_RFC) ? T_MRD : T_RFC;
  localparam int GAP_MAX  = (GAP_A > GAP_B) ? GAP_A : GAP_B;
  localparam int WAIT_MAX = (STAB_CYC > GAP_MAX) ? STAB_CYC : GAP_MAX;
  localparam int TW       = $clog2(WAIT_MAX + 1);
  localparam int DW       = $clog2(DLL_CYC + 1);

  st_e               st_q, st_d;
  logic [2:0]        step_q, step_d, idx;
  logic              cke_q, cke_d, rdy_q, rdy_d;
  logic              w_ld, w_zero, dll_ld, dll_zero;
  logic [TW-1:0]     w_val;
  cmd_e              cmd_d, rom_cmd;
  logic [TW-1:0]     rom_gap;
  logic [3:0]        ctl_d, ctl_q;
  logic [1:0]        ba_d, ba_q;
  logic [ADDR_W-1:0] addr_d, addr_q;

  assign idx = (st_q == S_SEQ) ? step_q + 3'd1 : 3'd0;

  ddr_init_step #(
    .TW(TW), .T_XP(T_XP), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC)
  ) u_step (
    .idx_i(idx), .cmd_o(rom_cmd), .gap_o(rom_gap)
  );

  ddr_init_timer #(.W(TW)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(w_ld), .val_i(w_val), .zero_o(w_zero)
  );

  ddr_init_timer #(.W(DW)) u_dll (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(dll_ld), .val_i(DW'(DLL_CYC)),
    .zero_o(dll_zero)
  );

  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    cke_d  = cke_q;
    rdy_d  = rdy_q;
    cmd_d  = C_NOP;
    w_ld   = 1'b0;
    w_val  = '0;
    dll_ld = 1'b0;
    if (!clk_en_i) begin
      st_d  = S_OFF;
      cke_d = 1'b0;
      rdy_d = 1'b0;
    end else begin
      unique case (st_q)
        S_OFF: begin
          st_d  = S_STAB;
          w_ld  = 1'b1;
          w_val = TW'(STAB_CYC);
        end
        S_STAB: begin
          if (pdn_clr_i && w_zero) begin
            st_d   = S_SEQ;
            cke_d  = 1'b1;
            step_d = 3'd0;
            w_ld   = 1'b1;
            w_val  = rom_gap;
          end
        end
        S_SEQ, S_RDY: begin
          if (pdn_req_i) begin
            // power-down: rerun allowed immediately, clock already stable
            st_d  = S_STAB;
            cke_d = 1'b0;
            rdy_d = 1'b0;
            w_ld  = 1'b1;
          end else if (st_q == S_SEQ && w_zero) begin
            if (step_q == LAST_STEP) begin
              if (dll_zero) begin
                st_d  = S_RDY;
                rdy_d = 1'b1;
              end
            end else begin
              step_d = idx;
              cmd_d  = rom_cmd;
              w_ld   = 1'b1;
              w_val  = rom_gap;
              dll_ld = (rom_cmd == C_MRS_DLL);
            end
          end
        end
        default: st_d = S_OFF;
      endcase
    end
  end

  ddr_init_cmd_enc #(.ADDR_W(ADDR_W)) u_enc (
    .cmd_i(cmd_d), .cas_lat_i(cas_lat_i), .drv_weak_i(drv_weak_i),
    .ctl_o(ctl_d), .ba_o(ba_d), .addr_o(addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_OFF;
      step_q <= '0;
      cke_q  <= 1'b0;
      rdy_q  <= 1'b0;
      ctl_q  <= 4'b0111;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      cke_q  <= cke_d;
      rdy_q  <= rdy_d;
      ctl_q  <= ctl_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
    end
  end

  assign mem_clk_en_o = (st_q != S_OFF);
  assign cke_o        = cke_q;
  assign ready_o      = rdy_q;
  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = ctl_q;
  assign ba_o         = ba_q;
  assign addr_o       = addr_q;
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
  parameter int ADDR_W   = 13,
  parameter int STAB_CYC = 50000,
  parameter int DLL_CYC  = 200,
  parameter int T_MRD    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pdn_clr_i,
  input logic              pdn_req_i,
  input logic              mem_clk_en_o,
  input logic              cke_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              ready_o
);
  logic is_nop, is_cmd, is_mode, is_dll_rst;
  logic [31:0] run_cnt, since_cmd, since_dll;
  logic last_mode, dll_seen;

  assign is_nop     = !cs_n_o && ras_n_o && cas_n_o && we_n_o;
  assign is_cmd     = !cs_n_o && !is_nop;
  assign is_mode    = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;
  assign is_dll_rst = is_mode && (ba_o == 2'b00) && addr_o[8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_cnt   <= '0;
      since_cmd <= '0;
      since_dll <= '0;
      last_mode <= 1'b0;
      dll_seen  <= 1'b0;
    end else begin
      if (!mem_clk_en_o)                 run_cnt <= '0;
      else if (run_cnt < STAB_CYC)       run_cnt <= run_cnt + 1;
      if (is_cmd)                        since_cmd <= '0;
      else if (since_cmd < 32'hFFFF)     since_cmd <= since_cmd + 1;
      if (!cke_o)                        last_mode <= 1'b0;
      else if (is_cmd)                   last_mode <= is_mode;
      if (is_dll_rst) begin
        since_dll <= '0;
        dll_seen  <= 1'b1;
      end else begin
        if (!cke_o)                      dll_seen <= 1'b0;
        if (since_dll < DLL_CYC)         since_dll <= since_dll + 1;
      end
    end
  end

  p_gated_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_clk_en_o |-> (!cke_o && !ready_o && is_nop));

  p_cke_low_nop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> is_nop);

  p_cke_after_stab_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (mem_clk_en_o && run_cnt >= STAB_CYC));

  p_early_clr_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_clr_i && !cke_o && run_cnt < STAB_CYC) |=> !cke_o);

  p_mrd_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && last_mode) |-> since_cmd >= T_MRD);

  p_ready_after_dll_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (dll_seen && since_dll >= DLL_CYC));

  p_ready_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (is_nop && cke_o && mem_clk_en_o));

  p_pdn_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_req_i && cke_o) |=> (!cke_o && !ready_o));
endmodule

bind ddr_init_seq ddr_init_seq_chk #(
  .ADDR_W(ADDR_W), .STAB_CYC(STAB_CYC), .DLL_CYC(DLL_CYC), .T_MRD(T_MRD)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pdn_clr_i(pdn_clr_i), .pdn_req_i(pdn_req_i),
  .mem_clk_en_o(mem_clk_en_o), .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o), .ready_o(ready_o)
);

// File: tb/tb_ddr_init_seq.sv
`timescale 1ns/1ps
module tb_ddr_init_seq;
  localparam int ADDR_W   = 13;
  localparam int STAB_CYC = 20;
  localparam int DLL_CYC  = 40;
  localparam int T_XP     = 1;
  localparam int T_RP     = 2;
  localparam int T_MRD    = 2;
  localparam int T_RFC    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0, pdn_clr = 1'b0, pdn_req = 1'b0;
  logic [2:0] cas_lat = 3'd2;
  logic drv_weak = 1'b0;
  logic mclk, cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [1:0] ba;
  logic [ADDR_W-1:0] addr;

  always #2 clk = ~clk;

  ddr_init_seq #(
    .ADDR_W(ADDR_W), .STAB_CYC(STAB_CYC), .DLL_CYC(DLL_CYC),
    .T_XP(T_XP), .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .pdn_clr_i(pdn_clr),
    .pdn_req_i(pdn_req), .cas_lat_i(cas_lat), .drv_weak_i(drv_weak),
    .mem_clk_en_o(mclk), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .ready_o(ready)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  int lg_n = 0, rdy_cyc = -1;
  logic rdy_prev = 1'b0;
  int lg_cyc[16];
  logic [2:0] lg_code[16];
  logic [1:0] lg_ba[16];
  logic [ADDR_W-1:0] lg_addr[16];

  always @(negedge clk) begin
    if (!cs_n && {ras_n, cas_n, we_n} != 3'b111) begin
      if (lg_n < 16) begin
        lg_cyc[lg_n]  = cyc;
        lg_code[lg_n] = {ras_n, cas_n, we_n};
        lg_ba[lg_n]   = ba;
        lg_addr[lg_n] = addr;
      end
      lg_n = lg_n + 1;
    end
    if (ready && !rdy_prev && rdy_cyc < 0) rdy_cyc = cyc;
    rdy_prev = ready;
  end

  task automatic check_eq(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic clear_log();
    lg_n = 0;
    rdy_cyc = -1;
  endtask

  function automatic int gap_of(int i);
    case (i)
      0: return T_XP;
      1, 4: return T_RP;
      5, 6: return T_RFC;
      default: return T_MRD;
    endcase
  endfunction

  function automatic int code_of(int i);
    case (i)
      1, 4: return 3'b010;
      5, 6: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int ba_of(int i);
    return (i == 2) ? 1 : 0;
  endfunction

  function automatic int addr_of(int i, logic [2:0] cl, logic dw);
    case (i)
      1, 4: return 1 << 10;
      2: return int'(dw) << 1;
      3: return (1 << 8) | (int'(cl) << 4) | 2;
      7: return (int'(cl) << 4) | 2;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int i);
    case (i)
      1, 2, 3: return "R4";
      7: return "R7";
      default: return "R6";
    endcase
  endfunction

  // f: edge at which the clear strobe is accepted
  task automatic verify_run(int f, logic [2:0] cl, logic dw);
    int m[8];
    int fin, rdy;
    m[0] = f;
    for (int i = 1; i < 8; i++) m[i] = m[i-1] + gap_of(i-1) + 1;
    fin = m[7] + T_MRD + 1;
    rdy = (fin > m[3] + DLL_CYC + 1) ? fin : m[3] + DLL_CYC + 1;
    wait_to(rdy + 6);
    check_eq("R8 command count incl. quiet while ready", lg_n, 7);
    for (int i = 1; i < 8; i++) begin
      if (i <= lg_n) begin
        check_eq(req_of(i), lg_cyc[i-1], m[i]);
        check_eq(req_of(i), int'(lg_code[i-1]), code_of(i));
        check_eq(req_of(i), int'(lg_ba[i-1]), ba_of(i));
        check_eq(i == 3 ? "R7" : req_of(i), int'(lg_addr[i-1]), addr_of(i, cl, dw));
      end
    end
    check_eq("R5 spacing after DLL-reset mode set", lg_cyc[3] - lg_cyc[2], T_MRD + 1);
    check_eq("R8 ready rise cycle", rdy_cyc, rdy);
    check_eq("R8 ready held", int'(ready), 1);
  endtask

  task automatic pulse_req();
    pdn_req = 1'b1;
    @(negedge clk);
    pdn_req = 1'b0;
  endtask

  int e, f, c, k, n_hold;

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check_eq("R1 clk gate in reset", int'(mclk), 0);
    check_eq("R1 cke in reset", int'(cke), 0);
    check_eq("R1 ready in reset", int'(ready), 0);
    check_eq("R1 NOP in reset", int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R2 clock stays gated without request", int'(mclk), 0);

    // run 1: random early strobe, random late acceptance
    cas_lat = 3'($urandom % 8);
    drv_weak = 1'($urandom % 2);
    clk_en = 1'b1;
    e = cyc + 1;
    @(negedge clk);
    check_eq("R2 clock starts", int'(mclk), 1);
    check_eq("R2 cke low while stabilizing", int'(cke), 0);
    c = e + int'($urandom % STAB_CYC);
    wait_to(c);
    pdn_clr = 1'b1;
    @(negedge clk);
    pdn_clr = 1'b0;
    check_eq("R3 early clear ignored", int'(cke), 0);
    wait_to(e + STAB_CYC + int'($urandom % 4));
    clear_log();
    pdn_clr = 1'b1;
    f = cyc + 1;
    @(negedge clk);
    pdn_clr = 1'b0;
    check_eq("R3 cke rises on accepted clear", int'(cke), 1);
    check_eq("R8 ready low in script", int'(ready), 0);
    verify_run(f, cas_lat, drv_weak);

    // runs 2..5: power-down from ready or mid-script, then rerun
    for (int r = 0; r < 4; r++) begin
      pulse_req();
      check_eq("R9 cke drops on power-down", int'(cke), 0);
      check_eq("R9 ready drops on power-down", int'(ready), 0);
      if (r % 2 == 1) begin
        clear_log();
        pdn_clr = 1'b1;
        @(negedge clk);
        pdn_clr = 1'b0;
        k = 2 + int'($urandom % 40);
        repeat (k) @(negedge clk);
        pulse_req();
        check_eq("R9 cke drops mid-script", int'(cke), 0);
        n_hold = lg_n;
        repeat (30) @(negedge clk);
        check_eq("R9 no command after abort", lg_n, n_hold);
      end
      cas_lat = 3'($urandom % 8);
      drv_weak = 1'($urandom % 2);
      clear_log();
      pdn_clr = 1'b1;
      f = cyc + 1;
      @(negedge clk);
      pdn_clr = 1'b0;
      check_eq("R9 rerun accepted at once", int'(cke), 1);
      verify_run(f, cas_lat, drv_weak);
    end

    // clock request withdrawn, then exact stabilization boundary
    clk_en = 1'b0;
    @(negedge clk);
    check_eq("R2 clock gated on withdraw", int'(mclk), 0);
    check_eq("R2 cke low on withdraw", int'(cke), 0);
    check_eq("R2 ready low on withdraw", int'(ready), 0);
    check_eq("R2 NOP on withdraw", int'({cs_n, ras_n, cas_n, we_n}), 4'b0111);
    repeat (3) @(negedge clk);
    clk_en = 1'b1;
    e = cyc + 1;
    @(negedge clk);
    @(negedge clk);
    pulse_req();
    check_eq("R9 request ignored while stabilizing", int'(cke), 0);
    wait_to(e + STAB_CYC - 1);
    clear_log();
    pdn_clr = 1'b1;
    @(negedge clk);
    check_eq("R3 clear one edge early ignored", int'(cke), 0);
    @(negedge clk);
    pdn_clr = 1'b0;
    check_eq("R3 clear at boundary accepted", int'(cke), 1);
    verify_run(e + STAB_CYC + 1, cas_lat, drv_weak);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc == 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule